// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the engine of one DMA channel. Once a legal configuration is in place and a start pulse arrives, it moves a programmed number of bytes from a source address to a destination address. Each unit takes one read cycle and then one write cycle on a simple single-beat memory bus with a ready handshake. The source and the destination each follow their own address mode: fixed, incrementing, or wrapping inside a window given by a base address and a window length. The unit is a byte, a half-word or a word. Units are grouped into bursts of one or four.

In software mode the channel runs until the byte count is used up and does not wait for anything. In hardware mode each burst waits for the request line of the selected peripheral. After each burst the channel drives a one-cycle acknowledge back to the peripheral, and it looks at the request again only after that acknowledge. A stop pulse halts the channel at the next unit boundary. The busy output stays high until the channel has actually halted. Burst-done and transfer-done event pulses are meant for the interrupt logic of the channel.

The states are IDLE, WAIT_REQ, READ, WRITE and ACK. The transitions are:
- IDLE to READ on a legal start in software mode.
- IDLE to WAIT_REQ on a legal start in hardware mode.
- WAIT_REQ to READ when the request is high.
- READ to WRITE when the read is accepted.
- WRITE to ACK at the end of a burst in hardware mode.
- WRITE to READ for the next unit.
- WRITE to IDLE on the last unit or a pending stop.
- ACK to IDLE when the count is drained or a stop is pending.
- ACK to WAIT_REQ otherwise.
- WAIT_REQ to IDLE on a stop.

Configuration inputs must be held stable while busy is high.

Top module: `dma_chan_seq`

## Requirements
- R1: A start pulse is accepted only when the configuration is legal; otherwise it is ignored and busy and mem_req stay low. A legal configuration has a nonzero byte count that is a multiple of the unit size, a unit code other than 3, address modes other than 3, and word-aligned start addresses (low two bits zero). Unit codes are 0 byte, 1 half-word, 2 word.
- R2: Each unit is one read at the current source address followed by one write at the current destination address, with mem_size equal to the unit code. The write data is the low unit bytes of the read data, with the upper bits zero.
- R3: Address mode 0 keeps the address fixed. Mode 1 adds 1, 2 or 4 (the unit size in bytes) after every unit.
- R4: In address mode 2 the address is advanced as in mode 1. If the result is at or beyond base plus window length, it returns to the base, so every access stays inside the window.
- R5: busy is high from the cycle after an accepted start until the transfer ends, and the channel moves exactly byte-count divided by unit-size units.
- R6: burst_done pulses for one cycle after every group of four units when the burst bit is 1, or after every unit when it is 0. It also pulses after a final shorter group.
- R7: xfer_done pulses for one cycle, in the same cycle as the final burst_done, and only when the whole count has been moved.
- R8: In hardware mode (hw_mode=1) no read of a burst starts until periph_req is high. In software mode periph_req is ignored.
- R9: In hardware mode periph_ack is high for exactly one cycle after each burst, in the same cycle as burst_done. Further bursts wait for a request seen after that acknowledge.
- R10: A stop pulse halts the channel at the next unit boundary. A bus cycle in progress keeps its address and direction until it is accepted, every started unit completes its write, and busy stays high until the halt.
- R11: After reset the channel is idle: busy, mem_req, periph_ack, burst_done and xfer_done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_mode | input | 2 | Source address mode (0 fixed, 1 increment, 2 wrap) |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_unit | input | 2 | Unit size code (0 byte, 1 half, 2 word) |
| cfg_burst4 | input | 1 | 1: four units per burst, 0: one |
| cfg_byte_cnt | input | CNT_W | Total bytes to move |
| cfg_hw_mode | input | 1 | 1: peripheral-paced, 0: free-running |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_src_wrap_base | input | ADDR_W | Source wrap window base |
| cfg_dst_wrap_base | input | ADDR_W | Destination wrap window base |
| cfg_wrap_len | input | WRAP_W | Wrap window length in bytes |
| start_req | input | 1 | Start pulse |
| stop_req | input | 1 | Stop pulse |
| busy | output | 1 | Channel running (start bit readback) |
| periph_req | input | 1 | Peripheral request level |
| periph_ack | output | 1 | One-cycle acknowledge after each burst |
| mem_req | output | 1 | Bus cycle valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Bus address |
| mem_size | output | 2 | Unit code of the cycle |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_ready | input | 1 | Bus cycle accepted this cycle |
| burst_done | output | 1 | End-of-burst event pulse |
| xfer_done | output | 1 | End-of-transfer event pulse |

## Verification
The bench goes after these corner cases:
- A byte-unit count that leaves a short last burst. A design that fails to close the partial group would miss a burst_done, or would run a pulse short.
- Half-word and word wrap windows entered mid-window. A wrong compare bound lets an address step one unit past the window, or jumps back a unit early.
- A stop landing on a stalled bus cycle. A careless design drops the cycle and leaves a read without its write.
- A hardware-mode peripheral that lowers its request at each acknowledge. A design that samples the request too early issues a read while the request is low.
- Illegal starts (zero count, misaligned count, reserved unit). These must leave busy low.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_INCR  = 2'b01,
        AM_WRAP  = 2'b10,
        AM_RSVD  = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        US_BYTE = 2'b00,
        US_HALF = 2'b01,
        US_WORD = 2'b10,
        US_RSVD = 2'b11
    } unit_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_READ,
        ST_WRITE,
        ST_ACK
    } seq_state_e;

    function automatic logic [2:0] unit_bytes(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            US_BYTE: n = 3'd1;
            US_HALF: n = 3'd2;
            US_WORD: n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dmaseq_addr_gen.sv
module dmaseq_addr_gen
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic [1:0]        mode,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] wrap_base,
    input  logic [WRAP_W-1:0] wrap_len,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] win_end;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        stepped = addr_q + ADDR_W'(step);
        win_end = wrap_base + ADDR_W'(wrap_len);
        unique case (addr_mode_e'(mode))
            AM_INCR: addr_nx = stepped;
            AM_WRAP: addr_nx = (stepped >= win_end) ? wrap_base : stepped;
            default: addr_nx = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (advance) begin
            addr_q <= addr_nx;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dmaseq_byte_ctr.sv
module dmaseq_byte_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic [2:0]       amt,
    output logic             final_unit,
    output logic             drained
);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - CNT_W'(amt);
        end
    end

    assign final_unit = (left_q == CNT_W'(amt));
    assign drained    = (left_q == '0);

endmodule

// File: rtl/dmaseq_beat_ctr.sv
module dmaseq_beat_ctr #(
    parameter int BURST_LONG = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    input  logic long_mode,
    output logic last_beat
);

    localparam int BW = (BURST_LONG > 1) ? $clog2(BURST_LONG) : 1;
    localparam logic [BW-1:0] LAST = BW'(BURST_LONG - 1);

    logic [BW-1:0] beat_q;

    assign last_beat = !long_mode || (beat_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clear) begin
            beat_q <= '0;
        end else if (bump) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WRAP_W     = 16,
    parameter int BURST_LONG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_src_mode,
    input  logic [1:0]        cfg_dst_mode,
    input  logic [1:0]        cfg_unit,
    input  logic              cfg_burst4,
    input  logic [CNT_W-1:0]  cfg_byte_cnt,
    input  logic              cfg_hw_mode,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [ADDR_W-1:0] cfg_src_wrap_base,
    input  logic [ADDR_W-1:0] cfg_dst_wrap_base,
    input  logic [WRAP_W-1:0] cfg_wrap_len,
    input  logic              start_req,
    input  logic              stop_req,
    output logic              busy,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              burst_done,
    output logic              xfer_done
);

    localparam int NUM_PORTS = 2;  // 0 source, 1 destination
    localparam int HALF_W    = (DATA_W >= 16) ? 16 : DATA_W;

    seq_state_e state_q, state_nx;

    logic [1:0] unit_q, smode_q, dmode_q;
    logic       burst4_q, hw_q, stop_pend_q;
    logic [DATA_W-1:0] data_q;

    logic cfg_ok, accept, unit_done, burst_end, stop_any;
    logic final_unit, drained, last_beat;
    logic [2:0] step;

    logic [ADDR_W-1:0] ag_start [NUM_PORTS];
    logic [ADDR_W-1:0] ag_base  [NUM_PORTS];
    logic [1:0]        ag_mode  [NUM_PORTS];
    logic [ADDR_W-1:0] ag_addr  [NUM_PORTS];

    // Configuration legality
    always_comb begin
        cfg_ok = (cfg_byte_cnt != '0)
              && (cfg_unit != US_RSVD)
              && (cfg_src_mode != AM_RSVD)
              && (cfg_dst_mode != AM_RSVD)
              && (cfg_src_addr[1:0] == 2'b00)
              && (cfg_dst_addr[1:0] == 2'b00);
        unique case (unit_e'(cfg_unit))
            US_HALF: cfg_ok = cfg_ok && (cfg_byte_cnt[0] == 1'b0);
            US_WORD: cfg_ok = cfg_ok && (cfg_byte_cnt[1:0] == 2'b00);
            default: cfg_ok = cfg_ok;
        endcase
    end

    assign accept    = (state_q == ST_IDLE) && start_req && cfg_ok;
    assign unit_done = (state_q == ST_WRITE) && mem_ready;
    assign burst_end = final_unit || last_beat;
    assign stop_any  = stop_pend_q || stop_req;
    assign step      = unit_bytes(unit_q);

    // Latched per-transfer configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q   <= US_BYTE;
            smode_q  <= AM_FIXED;
            dmode_q  <= AM_FIXED;
            burst4_q <= 1'b0;
            hw_q     <= 1'b0;
        end else if (accept) begin
            unit_q   <= cfg_unit;
            smode_q  <= cfg_src_mode;
            dmode_q  <= cfg_dst_mode;
            burst4_q <= cfg_burst4;
            hw_q     <= cfg_hw_mode;
        end
    end

    // Address generators, one per side
    always_comb begin
        ag_start[0] = cfg_src_addr;
        ag_start[1] = cfg_dst_addr;
        ag_base[0]  = cfg_src_wrap_base;
        ag_base[1]  = cfg_dst_wrap_base;
        ag_mode[0]  = smode_q;
        ag_mode[1]  = dmode_q;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_addr
        dmaseq_addr_gen #(
            .ADDR_W (ADDR_W),
            .WRAP_W (WRAP_W)
        ) u_ag (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (accept),
            .load_addr (ag_start[g]),
            .advance   (unit_done),
            .mode      (ag_mode[g]),
            .step      (step),
            .wrap_base (ag_base[g]),
            .wrap_len  (cfg_wrap_len),
            .addr      (ag_addr[g])
        );
    end

    dmaseq_byte_ctr #(
        .CNT_W (CNT_W)
    ) u_bytes (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_val   (cfg_byte_cnt),
        .dec        (unit_done),
        .amt        (step),
        .final_unit (final_unit),
        .drained    (drained)
    );

    dmaseq_beat_ctr #(
        .BURST_LONG (BURST_LONG)
    ) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept || (unit_done && final_unit)),
        .bump      (unit_done),
        .long_mode (burst4_q),
        .last_beat (last_beat)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_nx = cfg_hw_mode ? ST_WAIT_REQ : ST_READ;
            end
            ST_WAIT_REQ: begin
                if (stop_any)        state_nx = ST_IDLE;
                else if (periph_req) state_nx = ST_READ;
            end
            ST_READ: begin
                if (mem_ready) state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    if (burst_end && hw_q)           state_nx = ST_ACK;
                    else if (final_unit || stop_any) state_nx = ST_IDLE;
                    else                             state_nx = ST_READ;
                end
            end
            ST_ACK: begin
                if (drained || stop_any) state_nx = ST_IDLE;
                else                     state_nx = ST_WAIT_REQ;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Stop latch, the read data holding register and the event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_pend_q <= 1'b0;
            data_q      <= '0;
            burst_done  <= 1'b0;
            xfer_done   <= 1'b0;
        end else begin
            if (state_nx == ST_IDLE)              stop_pend_q <= 1'b0;
            else if (stop_req && state_q != ST_IDLE) stop_pend_q <= 1'b1;

            if (state_q == ST_READ && mem_ready) begin
                unique case (unit_e'(unit_q))
                    US_BYTE: data_q <= DATA_W'(mem_rdata[7:0]);
                    US_HALF: data_q <= DATA_W'(mem_rdata[HALF_W-1:0]);
                    default: data_q <= mem_rdata;
                endcase
            end

            burst_done <= unit_done && burst_end;
            xfer_done  <= unit_done && final_unit;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = ag_addr[0];
        periph_ack = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_WAIT_REQ: ;
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = ag_addr[0];
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ag_addr[1];
            end
            ST_ACK:      periph_ack = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    assign mem_size  = unit_q;
    assign mem_wdata = data_q;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int WRAP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_src_mode,
    input logic [1:0]        cfg_dst_mode,
    input logic [ADDR_W-1:0] cfg_src_wrap_base,
    input logic [ADDR_W-1:0] cfg_dst_wrap_base,
    input logic [WRAP_W-1:0] cfg_wrap_len,
    input logic              busy,
    input logic              periph_ack,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic              mem_ready,
    input logic              burst_done,
    input logic              xfer_done
);

    logic [ADDR_W-1:0] src_end, dst_end;
    assign src_end = cfg_src_wrap_base + ADDR_W'(cfg_wrap_len);
    assign dst_end = cfg_dst_wrap_base + ADDR_W'(cfg_wrap_len);

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R5

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size != 2'b11)); // R1

    AST_SRC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && cfg_src_mode == 2'b10)
            |-> (mem_addr >= cfg_src_wrap_base && mem_addr < src_end)); // R4

    AST_DST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && cfg_dst_mode == 2'b10)
            |-> (mem_addr >= cfg_dst_wrap_base && mem_addr < dst_end)); // R4

    AST_BURST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done || $past(mem_req && mem_we && mem_ready)); // R6

    AST_XFER_WITH_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> burst_done); // R7

    AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R7

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack); // R9

    AST_ACK_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> (burst_done && !mem_req)); // R9

endmodule

bind dma_chan_seq dma_chan_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WRAP_W (WRAP_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_src_mode      (cfg_src_mode),
    .cfg_dst_mode      (cfg_dst_mode),
    .cfg_src_wrap_base (cfg_src_wrap_base),
    .cfg_dst_wrap_base (cfg_dst_wrap_base),
    .cfg_wrap_len      (cfg_wrap_len),
    .busy              (busy),
    .periph_ack        (periph_ack),
    .mem_req           (mem_req),
    .mem_we            (mem_we),
    .mem_addr          (mem_addr),
    .mem_size          (mem_size),
    .mem_ready         (mem_ready),
    .burst_done        (burst_done),
    .xfer_done         (xfer_done)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0, cfg_unit = '0;
    logic        cfg_burst4 = 1'b0, cfg_hw_mode = 1'b0;
    logic [15:0] cfg_byte_cnt = '0, cfg_wrap_len = '0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [31:0] cfg_src_wrap_base = '0, cfg_dst_wrap_base = '0;
    logic        start_req = 1'b0, stop_req = 1'b0, periph_req = 1'b0;
    logic        busy, periph_ack, mem_req, mem_we, mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        burst_done, xfer_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[7:0], a[7:0] ^ 8'h96};
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    dma_chan_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_unit(cfg_unit), .cfg_burst4(cfg_burst4),
        .cfg_byte_cnt(cfg_byte_cnt), .cfg_hw_mode(cfg_hw_mode),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_wrap_base(cfg_src_wrap_base), .cfg_dst_wrap_base(cfg_dst_wrap_base),
        .cfg_wrap_len(cfg_wrap_len), .start_req(start_req), .stop_req(stop_req),
        .busy(busy), .periph_req(periph_req), .periph_ack(periph_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .burst_done(burst_done), .xfer_done(xfer_done)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard state
    logic [31:0] exp_src_q[$], exp_dst_q[$];
    logic [1:0]  exp_unit;
    string       cur_req = "R2";
    int rd_cnt, wr_cnt, bd_cnt, xd_cnt, ack_cnt, hw_viol;
    logic [31:0] last_rd;
    bit stall_en = 0, hw_auto = 0, flush_ok = 0;
    int gap = 0;

    // Bus ready driver
    initial begin
        logic [7:0] lf;
        lf = 8'hA7;
        forever begin
            @(posedge clk); #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            mem_ready = stall_en ? (lf[0] | lf[2]) : 1'b1;
        end
    end

    // Peripheral model: drops the request at each acknowledge, raises it later
    initial begin
        forever begin
            @(negedge clk);
            if (hw_auto) begin
                if (periph_ack) begin
                    periph_req = 1'b0;
                    gap = 5;
                end else if (gap > 0) begin
                    gap--;
                    if (gap == 0) periph_req = 1'b1;
                end
            end
        end
    end

    // Monitor: pops expected units as writes are accepted
    always @(negedge clk) begin
        if (rst_n) begin
            if (burst_done) bd_cnt++;
            if (xfer_done)  xd_cnt++;
            if (periph_ack) ack_cnt++;
            if (mem_req && mem_ready && !mem_we) begin
                rd_cnt++;
                last_rd = mem_addr;
                if (hw_auto && !periph_req) hw_viol++;
            end
            if (mem_req && mem_ready && mem_we) begin
                logic [31:0] es, ed, exd;
                wr_cnt++;
                if (exp_src_q.size() == 0) begin
                    check(0, cur_req, "unexpected write", mem_addr, 32'h0);
                end else begin
                    es = exp_src_q.pop_front();
                    ed = exp_dst_q.pop_front();
                    exd = mem_fn(es);
                    if (exp_unit == 2'd0) exd = exd & 32'h0000_00FF;
                    else if (exp_unit == 2'd1) exd = exd & 32'h0000_FFFF;
                    check(last_rd == es, cur_req, "source address", last_rd, es);
                    check(mem_addr == ed, cur_req, "destination address", mem_addr, ed);
                    check(mem_wdata == exd && mem_size == exp_unit, "R2", "write data", mem_wdata, exd);
                end
            end
        end
    end

    function automatic logic [31:0] adv(input logic [1:0] m, input logic [31:0] a,
                                        input logic [31:0] base, input logic [15:0] len,
                                        input int st);
        logic [31:0] t;
        t = a + 32'(st);
        if (m == 2'd1) return t;
        if (m == 2'd2) return (t >= base + 32'(len)) ? base : t;
        return a;
    endfunction

    task automatic setup(input logic [1:0] sm, input logic [1:0] dm, input logic [1:0] u,
                         input bit b4, input logic [15:0] cnt, input bit hw,
                         input logic [31:0] sa, input logic [31:0] da,
                         input logic [31:0] sb, input logic [31:0] db, input logic [15:0] wl);
        int st, n;
        logic [31:0] s, d;
        cfg_src_mode = sm; cfg_dst_mode = dm; cfg_unit = u; cfg_burst4 = b4;
        cfg_byte_cnt = cnt; cfg_hw_mode = hw; cfg_src_addr = sa; cfg_dst_addr = da;
        cfg_src_wrap_base = sb; cfg_dst_wrap_base = db; cfg_wrap_len = wl;
        exp_unit = u;
        st = (u == 2'd0) ? 1 : (u == 2'd1) ? 2 : 4;
        n = int'(cnt) / st;
        s = sa; d = da;
        exp_src_q.delete(); exp_dst_q.delete();
        for (int i = 0; i < n; i++) begin
            exp_src_q.push_back(s);
            exp_dst_q.push_back(d);
            s = adv(sm, s, sb, wl, st);
            d = adv(dm, d, db, wl, st);
        end
        rd_cnt = 0; wr_cnt = 0; bd_cnt = 0; xd_cnt = 0; ack_cnt = 0; hw_viol = 0;
    endtask

    task automatic pulse_start;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic wait_idle;
        int lim;
        lim = 0;
        while (busy && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
        check(lim < 20000, cur_req, "channel did not return idle", 32'(lim), 32'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run(input int units, input int bursts, input int acks);
        check(exp_src_q.size() == 0, "R5", "units left unmoved", 32'(exp_src_q.size()), 32'h0);
        check(wr_cnt == units, "R5", "unit count", 32'(wr_cnt), 32'(units));
        check(bd_cnt == bursts, "R6", "burst_done count", 32'(bd_cnt), 32'(bursts));
        check(xd_cnt == 1, "R7", "xfer_done count", 32'(xd_cnt), 32'h1);
        check(ack_cnt == acks, "R9", "acknowledge count", 32'(ack_cnt), 32'(acks));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !mem_req && !periph_ack && !burst_done && !xfer_done,
              "R11", "outputs during reset", {27'h0, busy, mem_req, periph_ack, burst_done, xfer_done}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !mem_req, "R11", "idle after reset", {30'h0, busy, mem_req}, 32'h0);

        // Word units, both sides increment, single-unit bursts, request ignored (R3, R8)
        cur_req = "R3";
        setup(2'd1, 2'd1, 2'd2, 1'b0, 16'd16, 1'b0, 32'h1000, 32'h4000, 32'h0, 32'h0, 16'd0);
        pulse_start;
        check(busy == 1'b1, "R5", "busy after start", 32'(busy), 32'h1);
        wait_idle;
        finish_run(4, 4, 0);

        // Byte units, fixed destination, bursts of four with a short tail (R6)
        cur_req = "R3";
        setup(2'd1, 2'd0, 2'd0, 1'b1, 16'd10, 1'b0, 32'h2000, 32'h5000, 32'h0, 32'h0, 16'd0);
        pulse_start;
        wait_idle;
        finish_run(10, 3, 0);

        // Half-word source wrapping from mid-window (R4)
        cur_req = "R4";
        setup(2'd2, 2'd1, 2'd1, 1'b1, 16'd24, 1'b0, 32'h0104, 32'h6000, 32'h0100, 32'h0, 16'd8);
        pulse_start;
        wait_idle;
        finish_run(12, 3, 0);

        // Word destination wrap, fixed source, bus stalls (R4, R10)
        cur_req = "R4";
        stall_en = 1;
        setup(2'd0, 2'd2, 2'd2, 1'b1, 16'd40, 1'b0, 32'h3000, 32'h2008, 32'h0, 32'h2000, 16'd16);
        pulse_start;
        wait_idle;
        finish_run(10, 3, 0);
        stall_en = 0;

        // Illegal starts are ignored (R1)
        cur_req = "R1";
        setup(2'd1, 2'd1, 2'd2, 1'b0, 16'd0, 1'b0, 32'h1000, 32'h4000, 32'h0, 32'h0, 16'd0);
        pulse_start; repeat (4) @(negedge clk);
        check(!busy && !mem_req && wr_cnt == 0, "R1", "zero count accepted", 32'(busy), 32'h0);
        cfg_byte_cnt = 16'd6;
        pulse_start; repeat (4) @(negedge clk);
        check(!busy && wr_cnt == 0, "R1", "non-multiple count accepted", 32'(busy), 32'h0);
        cfg_byte_cnt = 16'd8; cfg_unit = 2'd3;
        pulse_start; repeat (4) @(negedge clk);
        check(!busy && wr_cnt == 0, "R1", "reserved unit accepted", 32'(busy), 32'h0);
        cfg_unit = 2'd2; cfg_src_addr = 32'h1002;
        pulse_start; repeat (4) @(negedge clk);
        check(!busy && wr_cnt == 0, "R1", "misaligned start accepted", 32'(busy), 32'h0);

        // Hardware mode: wait for request, acknowledge per burst (R8, R9)
        cur_req = "R8";
        periph_req = 1'b0;
        setup(2'd1, 2'd0, 2'd2, 1'b1, 16'd40, 1'b1, 32'h7000, 32'h0800, 32'h0, 32'h0, 16'd0);
        pulse_start;
        repeat (10) @(negedge clk);
        check(busy && rd_cnt == 0, "R8", "read without request", 32'(rd_cnt), 32'h0);
        periph_req = 1'b1;
        hw_auto = 1;
        wait_idle;
        hw_auto = 0;
        periph_req = 1'b0;
        check(hw_viol == 0, "R9", "read while request low after ack", 32'(hw_viol), 32'h0);
        finish_run(10, 3, 3);

        // Stop mid-run with stalls (R10)
        cur_req = "R10";
        stall_en = 1;
        setup(2'd1, 2'd1, 2'd2, 1'b0, 16'd256, 1'b0, 32'h8000, 32'h9000, 32'h0, 32'h0, 16'd0);
        pulse_start;
        repeat (20) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        wait_idle;
        stall_en = 0;
        check(wr_cnt > 0 && wr_cnt < 64, "R10", "stop did not halt early", 32'(wr_cnt), 32'd63);
        check(rd_cnt == wr_cnt, "R10", "unit left half done", 32'(rd_cnt), 32'(wr_cnt));
        check(xd_cnt == 0, "R10", "xfer_done after stop", 32'(xd_cnt), 32'h0);
        repeat (5) @(negedge clk);
        check(!busy && !mem_req, "R10", "bus activity after halt", 32'(mem_req), 32'h0);
        exp_src_q.delete(); exp_dst_q.delete();

        // Restart after stop works normally (R5)
        cur_req = "R5";
        setup(2'd1, 2'd1, 2'd1, 1'b1, 16'd8, 1'b0, 32'hA000, 32'hB000, 32'h0, 32'h0, 16'd0);
        pulse_start;
        wait_idle;
        finish_run(4, 1, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "R5", "watchdog expired", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule